// File: doc/BRIEF.md
# UART Register Bank with Receive Queue

This block is the byte-wide register interface of a 16450/16550-class serial controller. A host reads and writes a small eight-location register space through a simple strobe port. A deserializer hands over each received character through a push port, and the block keeps those characters in a circular queue until the host reads them. It also tracks the line status flags that the host polls: data available, overrun and the error summary.

Setting the bank bit of the line control register swaps the two lowest locations. Instead of the receive data and the interrupt enable register, they then reach the low and high bytes of the baud-rate divisor. Writing the low divisor byte also registers a character time: the number of clock ticks one serial frame takes, computed from the divisor and the frame layout in the line control register. Received characters are trimmed to the configured word length before they are stored. The queue holds sixteen entries when the deep-queue parameter is set and a single entry otherwise.

Top module: `uart_regbank`

## Requirements
- R1: After reset, every register (line control, interrupt enable, scratch, both divisor bytes, character time, status flags) is zero and the queue is empty, so a read of the line status location returns 0x00.
- R2: Line control bit 7 is the bank bit. While it is 1, location 0 reads and writes the low divisor byte and location 1 the high divisor byte. While it is 0, location 0 reads the receive queue and location 1 is the interrupt enable register. A data read with the bank bit set does not remove a queue entry.
- R3: A write to the low divisor byte registers char_time = divisor × 16 × frame bits. The divisor is the high byte already held combined with the byte being written. Frame bits = 1 start + (LCR[1:0] + 5) data + LCR[3] parity + (LCR[2] ? 2 : 1) stop. A write to the high byte or to the line control register leaves char_time unchanged.
- R4: The queue holds 16 characters when FIFO_DEEP = 1 and one character when FIFO_DEEP = 0.
- R5: A push while the queue holds its full depth discards the character and sets line status bit 1 (overrun) and bit 7 (error summary).
- R6: Every push, whether accepted or discarded, sets line status bit 0 (data ready) on the following cycle.
- R7: LCR[1:0] selects a word length of LCR[1:0] + 5 bits. Received bits at and above that length are cleared before the character is stored.
- R8: A read of location 0 with the bank bit clear returns the oldest stored character and removes it, so characters come back in push order. Read data appears on bus_rdata one cycle after the read strobe and holds until the next read.
- R9: Data ready clears when a read empties the queue. A data read of an empty queue returns 0x00.
- R10: Location 3 reads back the line control register and location 7 reads back the last scratch value written. Locations 2, 4 and 6 read 0x00 and ignore writes.
- R11: Location 5 returns the line status as {error, 5'b0, overrun, data ready}. Reading it clears overrun and error, unless a push into a full queue sets them again in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register location |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| rx_push | input | 1 | A received character is offered this cycle |
| rx_char | input | 8 | Received character before word-length trimming |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| divisor | output | 16 | Baud-rate divisor {high, low} |
| char_time | output | 24 | Clock ticks per serial frame |
| rx_ready | output | 1 | Data ready flag |
| rx_overrun | output | 1 | Overrun flag |
| rx_error | output | 1 | Receive error summary flag |

## Verification
On every cycle the checker confirms four things about the queue: the fill level never exceeds the configured depth, a push into a full queue raises both overrun and error, any push leaves data ready set, and a clear data-ready flag always means an empty queue. It also checks that a banked write to location 0 lands in the low divisor byte, and that the divisor never moves without a write. Queue ordering, word-length trimming, the char_time arithmetic for different frame layouts, the clear-on-read status and the read-back of each location are data-dependent. Only the bench scenarios can show these, and they run against both the sixteen-entry and the one-entry configuration.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;

    // Register locations
    localparam logic [ADDR_W-1:0] LOC_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] LOC_IEN  = 3'd1;
    localparam logic [ADDR_W-1:0] LOC_LCTL = 3'd3;
    localparam logic [ADDR_W-1:0] LOC_LSTS = 3'd5;
    localparam logic [ADDR_W-1:0] LOC_SCR  = 3'd7;

    // Line control fields
    localparam int LCTL_BANK   = 7;
    localparam int LCTL_PARITY = 3;
    localparam int LCTL_STOP2  = 2;

    // Keep mask for a word-length code (length = code + 5)
    function automatic logic [BYTE_W-1:0] word_mask(input logic [1:0] code);
        logic [BYTE_W-1:0] m;
        case (code)
            2'd0:    m = 8'h1F;
            2'd1:    m = 8'h3F;
            2'd2:    m = 8'h7F;
            default: m = 8'hFF;
        endcase
        return m;
    endfunction

    // Total bits in one serial frame for a line control value
    function automatic logic [3:0] frame_bits(input logic [BYTE_W-1:0] lctl);
        logic [3:0] n;
        n = 4'd1 + 4'd5 + {2'b00, lctl[1:0]} + {3'b000, lctl[LCTL_PARITY]};
        n = n + (lctl[LCTL_STOP2] ? 4'd2 : 4'd1);
        return n;
    endfunction

endpackage

// File: rtl/uart_rxq.sv
module uart_rxq #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head_data,
    output logic [CNT_W-1:0] level,
    output logic             full
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr_ptr;
        logic [PTR_W-1:0]        rd_ptr;
        logic [CNT_W-1:0]        cnt;
    } q_state_t;

    q_state_t s_q, s_d;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    logic accept;
    logic take;

    always_comb begin
        s_d    = s_q;
        accept = push && (s_q.cnt != CNT_W'(DEPTH));
        take   = pop && (s_q.cnt != '0);

        if (accept) begin
            s_d.mem[s_q.wr_ptr] = push_data;
            s_d.wr_ptr          = wrap_inc(s_q.wr_ptr);
        end
        if (take) begin
            s_d.rd_ptr = wrap_inc(s_q.rd_ptr);
        end
        s_d.cnt = s_q.cnt + CNT_W'(accept) - CNT_W'(take);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head_data = s_q.mem[s_q.rd_ptr];
    assign level     = s_q.cnt;
    assign full      = (s_q.cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/uart_chartime.sv
module uart_chartime
    import uart_regbank_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int CT_W  = DIV_W + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DIV_W-1:0]  div_in,
    input  logic [BYTE_W-1:0] lctl,
    output logic [CT_W-1:0]   char_time
);

    logic [CT_W-1:0] ct_q, ct_d;
    logic [CT_W-1:0] product;

    always_comb begin
        product = CT_W'(div_in) * CT_W'(frame_bits(lctl));
        ct_d    = load ? (product << 4) : ct_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ct_q <= '0;
        end else begin
            ct_q <= ct_d;
        end
    end

    assign char_time = ct_q;

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
#(
    parameter int FIFO_DEEP  = 1,
    parameter int DEEP_DEPTH = 16,
    parameter int DIV_W      = 16,
    parameter int CT_W       = DIV_W + 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic        rx_push,
    input  logic [7:0]  rx_char,
    output logic [7:0]  bus_rdata,
    output logic [15:0] divisor,
    output logic [23:0] char_time,
    output logic        rx_ready,
    output logic        rx_overrun,
    output logic        rx_error
);

    localparam int DEPTH = (FIFO_DEEP != 0) ? DEEP_DEPTH : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int HALF  = DIV_W / 2;

    typedef struct packed {
        logic [BYTE_W-1:0] lctl;
        logic [BYTE_W-1:0] ien;
        logic [BYTE_W-1:0] scr;
        logic [HALF-1:0]   div_lo;
        logic [HALF-1:0]   div_hi;
        logic              ovr;
        logic              err;
        logic              rdy;
        logic [BYTE_W-1:0] rdata;
    } regs_t;

    regs_t r_q, r_d;

    logic              bank_sel;
    logic              q_pop;
    logic              ct_load;
    logic [BYTE_W-1:0] rx_trim;
    logic [BYTE_W-1:0] q_head;
    logic [CNT_W-1:0]  q_level;
    logic              q_full;
    logic [BYTE_W-1:0] rd_val;
    logic [DIV_W-1:0]  ct_div;

    assign bank_sel = r_q.lctl[LCTL_BANK];
    assign rx_trim  = rx_char & word_mask(r_q.lctl[1:0]);
    assign q_pop    = bus_rd && (bus_addr == LOC_DATA) && !bank_sel;
    assign ct_load  = bus_wr && (bus_addr == LOC_DATA) && bank_sel;
    assign ct_div   = {r_q.div_hi, bus_wdata};

    uart_rxq #(
        .DEPTH (DEPTH),
        .W     (BYTE_W)
    ) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (rx_trim),
        .pop       (q_pop),
        .head_data (q_head),
        .level     (q_level),
        .full      (q_full)
    );

    uart_chartime #(
        .DIV_W (DIV_W),
        .CT_W  (CT_W)
    ) u_ct (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ct_load),
        .div_in    (ct_div),
        .lctl      (r_q.lctl),
        .char_time (char_time)
    );

    // Read multiplexer
    always_comb begin
        case (bus_addr)
            LOC_DATA: begin
                if (bank_sel)            rd_val = r_q.div_lo;
                else if (q_level != '0)  rd_val = q_head;
                else                     rd_val = '0;
            end
            LOC_IEN:  rd_val = bank_sel ? r_q.div_hi : r_q.ien;
            LOC_LCTL: rd_val = r_q.lctl;
            LOC_LSTS: rd_val = {r_q.err, 5'b00000, r_q.ovr, r_q.rdy};
            LOC_SCR:  rd_val = r_q.scr;
            default:  rd_val = '0;
        endcase
    end

    // Next-state logic
    always_comb begin
        r_d = r_q;

        if (bus_rd) begin
            r_d.rdata = rd_val;
        end

        if (bus_wr) begin
            case (bus_addr)
                LOC_DATA: if (bank_sel) r_d.div_lo = bus_wdata;
                LOC_IEN: begin
                    if (bank_sel) r_d.div_hi = bus_wdata;
                    else          r_d.ien    = bus_wdata;
                end
                LOC_LCTL: r_d.lctl = bus_wdata;
                LOC_SCR:  r_d.scr  = bus_wdata;
                default: ;
            endcase
        end

        // Status read clears the sticky error flags
        if (bus_rd && (bus_addr == LOC_LSTS)) begin
            r_d.ovr = 1'b0;
            r_d.err = 1'b0;
        end

        // A read that takes the last entry drops data ready
        if (q_pop && (q_level == CNT_W'(1))) begin
            r_d.rdy = 1'b0;
        end

        // Any push raises data ready; a full queue also flags overrun
        if (rx_push) begin
            r_d.rdy = 1'b1;
            if (q_full) begin
                r_d.ovr = 1'b1;
                r_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata  = r_q.rdata;
    assign divisor    = {r_q.div_hi, r_q.div_lo};
    assign rx_ready   = r_q.rdy;
    assign rx_overrun = r_q.ovr;
    assign rx_error   = r_q.err;

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_push,
    input logic             bus_wr,
    input logic [2:0]       bus_addr,
    input logic [7:0]       bus_wdata,
    input logic [15:0]      divisor,
    input logic             rx_ready,
    input logic             rx_overrun,
    input logic             rx_error,
    input logic             bank_sel,
    input logic [CNT_W-1:0] q_level,
    input logic             q_full
);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_level <= CNT_W'(DEPTH));

    // R5
    overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && q_full |=> rx_overrun && rx_error);

    // R6
    push_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> rx_ready);

    // R9
    idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ready |-> q_level == '0);

    // R2
    bank_low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bank_sel && bus_addr == 3'd0 |=> divisor[7:0] == $past(bus_wdata));

    // R3
    divisor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(divisor));

endmodule

bind uart_regbank uart_regbank_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_push    (rx_push),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .divisor    (divisor),
    .rx_ready   (rx_ready),
    .rx_overrun (rx_overrun),
    .rx_error   (rx_error),
    .bank_sel   (bank_sel),
    .q_level    (q_level),
    .q_full     (q_full)
);

// File: tb/uart_regbank_test.sv
module uart_regbank_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_char = '0;

    logic [7:0]  bus_rdata;
    logic [15:0] divisor;
    logic [23:0] char_time;
    logic        rx_ready, rx_overrun, rx_error;

    logic [7:0]  s_rdata;
    logic [15:0] s_div;
    logic [23:0] s_ct;
    logic        s_ready, s_ovr, s_err;

    int checks = 0;
    int failures = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regbank #(.FIFO_DEEP(1)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .rx_push(rx_push), .rx_char(rx_char),
        .bus_rdata(bus_rdata), .divisor(divisor), .char_time(char_time),
        .rx_ready(rx_ready), .rx_overrun(rx_overrun), .rx_error(rx_error)
    );

    uart_regbank #(.FIFO_DEEP(0)) uut_shallow (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .rx_push(rx_push), .rx_char(rx_char),
        .bus_rdata(s_rdata), .divisor(s_div), .char_time(s_ct),
        .rx_ready(s_ready), .rx_overrun(s_ovr), .rx_error(s_err)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: issues a read and hands the expected value to the scoreboard
    task automatic rd_exp(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push(input logic [7:0] c);
        @(negedge clk);
        rx_push = 1'b1; rx_char = c;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    // Monitor: read data is valid one cycle after the strobe
    initial begin
        forever begin
            logic seen;
            @(posedge clk);
            seen = bus_rd;
            @(negedge clk);
            if (seen) begin
                if (exp_q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R8 unexpected read actual=0x%0h expected=none", bus_rdata);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, bus_rdata, e);
                end
            end
        end
    end

    function automatic longint exp_ct(input int dv, input logic [7:0] l);
        int bits;
        bits = 1 + 5 + int'(l[1:0]) + int'(l[3]) + (l[2] ? 2 : 1);
        return longint'(dv) * 16 * bits;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 divisor", divisor, 0);
        check("R1 char_time", char_time, 0);
        check("R1 ready", rx_ready, 0);
        check("R1 overrun", rx_overrun, 0);
        rd_exp(3'd5, 8'h00, "R1 status after reset");
        rd_exp(3'd3, 8'h00, "R1 line control after reset");
        rd_exp(3'd0, 8'h00, "R9 empty read");

        // R4 depth difference, R6 ready on push
        wr(3'd3, 8'h03);
        push(8'hA5);
        push(8'h3C);
        check("R6 ready deep", rx_ready, 1);
        check("R4 deep no overrun", rx_overrun, 0);
        check("R5 shallow overrun", s_ovr, 1);
        check("R5 shallow error", s_err, 1);
        check("R6 ready shallow", s_ready, 1);
        rd_exp(3'd0, 8'hA5, "R8 first in order");
        check("R4 shallow keeps first", s_rdata, 8'hA5);
        check("R9 ready after one read", rx_ready, 1);
        rd_exp(3'd0, 8'h3C, "R8 second in order");
        check("R4 shallow empty read", s_rdata, 8'h00);
        check("R9 ready cleared", rx_ready, 0);
        rd_exp(3'd0, 8'h00, "R9 empty after drain");
        rd_exp(3'd5, 8'h00, "R11 status clean");

        // R7 word length trimming
        wr(3'd3, 8'h00); push(8'hFF); rd_exp(3'd0, 8'h1F, "R7 five bits");
        wr(3'd3, 8'h01); push(8'hFF); rd_exp(3'd0, 8'h3F, "R7 six bits");
        wr(3'd3, 8'h02); push(8'hFF); rd_exp(3'd0, 8'h7F, "R7 seven bits");
        wr(3'd3, 8'h03); push(8'hFF); rd_exp(3'd0, 8'hFF, "R7 eight bits");

        // R5 fill to depth then overflow, R11 clear on read
        for (int i = 0; i < 16; i++) push(8'(i * 17 + 1));
        check("R5 full no overrun yet", rx_overrun, 0);
        push(8'hEE);
        check("R5 overrun", rx_overrun, 1);
        check("R5 error", rx_error, 1);
        rd_exp(3'd5, 8'h83, "R11 status with overrun");
        rd_exp(3'd5, 8'h01, "R11 status after clear");
        for (int i = 0; i < 16; i++) rd_exp(3'd0, 8'(i * 17 + 1), "R8 fifo order");
        rd_exp(3'd0, 8'h00, "R5 dropped char absent");
        check("R9 ready after drain", rx_ready, 0);

        // R2 / R3 divisor bank and char time
        wr(3'd3, 8'h83);
        wr(3'd0, 8'h0C);
        check("R3 char time on low write", char_time, exp_ct(12, 8'h83));
        wr(3'd1, 8'h01);
        check("R2 divisor", divisor, 16'h010C);
        check("R3 high write keeps char time", char_time, exp_ct(12, 8'h83));
        rd_exp(3'd0, 8'h0C, "R2 low divisor read");
        rd_exp(3'd1, 8'h01, "R2 high divisor read");
        wr(3'd3, 8'h8F);
        check("R3 lcr write keeps char time", char_time, exp_ct(12, 8'h83));
        wr(3'd0, 8'h0C);
        check("R3 char time full frame", char_time, exp_ct(268, 8'h8F));
        push(8'h77);
        rd_exp(3'd0, 8'h0C, "R2 banked read gives divisor");
        check("R2 banked read keeps data", rx_ready, 1);
        wr(3'd3, 8'h03);
        wr(3'd1, 8'h5A);
        check("R2 enable write leaves divisor", divisor, 16'h010C);
        rd_exp(3'd1, 8'h5A, "R2 enable register read");
        rd_exp(3'd0, 8'h77, "R2 data after unbank");

        // R10 other locations
        wr(3'd7, 8'hC3);
        rd_exp(3'd7, 8'hC3, "R10 scratch");
        wr(3'd2, 8'hFF); wr(3'd4, 8'hFF); wr(3'd6, 8'hFF);
        rd_exp(3'd2, 8'h00, "R10 location 2");
        rd_exp(3'd4, 8'h00, "R10 location 4");
        rd_exp(3'd6, 8'h00, "R10 location 6");
        rd_exp(3'd3, 8'h03, "R10 line control");
        check("R10 divisor untouched", divisor, 16'h010C);

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; failures++;
            $display("FAIL R8 pending reads actual=%0d expected=0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule